// File: doc/BRIEF.md
# I2C Byte-Level Bus Master

This block is a single-master I2C controller that works one bus event at a time. The caller issues one of four commands: begin a transfer, end it, send a byte, or receive a byte. The block then runs the matching sequence on two open-drain lines. Neither line is ever driven high. Each line is either pulled low by asserting its output-enable or released to the external pull-up, and the block reads the true line levels back through its inputs. While a command runs `cmd_busy` is high. When the command ends, `done` pulses and the results sit on `rdata` and `ack_seen`.

The bus clock comes from the `half_div` input, which gives the length of each SCL half-period in system clocks. Every phase is timed only while SCL reads back at the level the master expects. A slave that holds SCL low therefore stalls the master instead of shortening its high phase. For each received byte the caller decides whether the master acknowledges it, so the last byte of a read can be refused before the transfer is closed.

Top module: `i2c_byte_master`

## Requirements
- R1: While reset is asserted and right after it, both output-enables are low, and `cmd_busy`, `bus_busy` and `done` are low.
- R2: `cmd_op` = 0 (begin) produces an SDA fall while SCL is high, possibly repeated while the bus is already held. The command finishes with SCL pulled low, and `bus_busy` rises together with its `done`.
- R3: `cmd_op` = 1 (end) produces an SDA rise while SCL is high. Exactly `half_div` system clocks after SDA is seen high, `done` pulses and `bus_busy` falls; this gap is the bus-free time.
- R4: During byte commands SDA changes only while SCL is low, so an observer of the lines sees no begin or end condition in the middle of a byte.
- R5: `cmd_op` = 2 (send) puts `cmd_wdata` on SDA most significant bit first, one bit per SCL pulse. On a ninth pulse the master releases SDA and samples it. `ack_seen` = 1 means SDA was low (acknowledged).
- R6: `cmd_op` = 3 (receive) samples eight bits from SDA, first bit into bit 7 of `rdata`. On the ninth pulse SDA is pulled low when `cmd_rd_nack` = 0 and left released when `cmd_rd_nack` = 1.
- R7: Every data-bit SCL high pulse lasts exactly max(`half_div`,1) + `SYNC_STAGES` system clocks, with `half_div` = 0 treated as 1. No SCL low period is shorter than `half_div`.
- R8: While another device holds SCL low after the master releases it, the master does not advance. After SCL rises, the high pulse still has its full length and the data is still correct.
- R9: A command presented while `cmd_busy` is high is ignored, and the running command completes unchanged.
- R10: `cmd_busy` is high from the cycle after a command is accepted until completion. `done` is high for exactly one cycle per command, at which point `cmd_busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request, accepted when `cmd_busy` is low |
| cmd_op | input | 2 | 0 begin, 1 end, 2 send byte, 3 receive byte |
| cmd_rd_nack | input | 1 | For receive: 1 leaves the ninth bit released (NACK) |
| cmd_wdata | input | DATA_W | Byte to send |
| half_div | input | DIV_W | SCL half-period in system clocks (0 acts as 1) |
| scl_in | input | 1 | Level of the SCL line |
| sda_in | input | 1 | Level of the SDA line |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| rdata | output | DATA_W | Last received byte |
| ack_seen | output | 1 | 1 when the ninth bit of the last byte was low |
| cmd_busy | output | 1 | A command is in progress |
| bus_busy | output | 1 | Bus owned between begin and end plus bus-free time |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench sweeps every byte value in both directions at the two shortest half-periods, and a strided set at longer ones. It watches the lines the way a slave would. A bit order reversed, a data change while SCL is high, or a misplaced ninth-bit drive shows up as a wrong captured byte or as a spurious begin or end condition. A slave model stretches the clock. A master that kept counting during the hold would produce high pulses shorter than the exact expected length. The bench also checks the bus-free gap after an end condition to the exact cycle. It injects a command in the middle of a byte, which a master that failed to ignore it would turn into a stray begin condition, and it tries a divider of zero, which a design without the clamp would treat as a huge half-period.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_STOP  = 2'd1,
    OP_WRITE = 2'd2,
    OP_READ  = 2'd3
  } i2cm_op_e;

  typedef enum logic [3:0] {
    S_IDLE = 4'd0,
    S_ST0  = 4'd1,
    S_ST1  = 4'd2,
    S_ST2  = 4'd3,
    S_ST3  = 4'd4,
    S_BLO  = 4'd5,
    S_BHI  = 4'd6,
    S_SP0  = 4'd7,
    S_SP1  = 4'd8,
    S_SP2  = 4'd9
  } i2cm_state_e;

endpackage

// File: rtl/i2cm_line_sync.sv
module i2cm_line_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);

  generate
    if (STAGES == 0) begin : g_bypass
      assign d_out = d_in;
    end else begin : g_chain
      logic [WIDTH-1:0] stage_q [STAGES];
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < STAGES; i++) stage_q[i] <= '1;
        end else begin
          stage_q[0] <= d_in;
          for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
      end
      assign d_out = stage_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/i2cm_phase_timer.sv
module i2cm_phase_timer #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             level_ok,
  input  logic [DIV_W-1:0] half_div,
  output logic             tick
);

  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] span;

  // a zero divider is clamped to one clock per half-period
  always_comb span = (half_div == '0) ? ONE : half_div;

  // counting only advances while the line reads back as intended
  assign tick = level_ok && !clr && (cnt_q == span - ONE);

  always_ff @(posedge clk) begin
    if (rst || clr || tick) cnt_q <= '0;
    else if (level_ok)      cnt_q <= cnt_q + ONE;
  end

endmodule

// File: rtl/i2cm_byte_shifter.sv
module i2cm_byte_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  input  logic         shin,
  output logic [W-1:0] data,
  output logic         msb
);

  logic [W-1:0] sr_q;

  always_ff @(posedge clk) begin
    if (rst)        sr_q <= '0;
    else if (load)  sr_q <= load_val;
    else if (shift) sr_q <= {sr_q[W-2:0], shin};
  end

  assign data = sr_q;
  assign msb  = sr_q[W-1];

endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
  import i2cm_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int DIV_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic              cmd_rd_nack,
  input  logic [DATA_W-1:0] cmd_wdata,
  input  logic [DIV_W-1:0]  half_div,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic [DATA_W-1:0] rdata,
  output logic              ack_seen,
  output logic              cmd_busy,
  output logic              bus_busy,
  output logic              done
);

  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W);

  i2cm_state_e      state;
  logic [CNT_W-1:0] bit_idx;
  logic             ninth_rel;
  logic             is_read;
  logic             scl_s, sda_s;
  logic             level_ok, tick;
  logic             sda_tgt;
  logic             accept;
  logic             sh_load, sh_shift, sh_msb;
  logic [DATA_W-1:0] sh_data, sh_init;

  // line input synchronisers
  i2cm_line_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .d_in ({scl_in, sda_in}),
    .d_out({scl_s, sda_s})
  );

  // SCL must read back the level implied by the output-enable
  assign level_ok = (scl_s == !scl_oe);

  i2cm_phase_timer #(.DIV_W(DIV_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .clr     (state == S_IDLE),
    .level_ok(level_ok),
    .half_div(half_div),
    .tick    (tick)
  );

  assign accept   = cmd_valid && (state == S_IDLE);
  assign sh_load  = accept && ((cmd_op == OP_WRITE) || (cmd_op == OP_READ));
  assign sh_init  = (cmd_op == OP_READ) ? {DATA_W{1'b1}} : cmd_wdata;
  assign sh_shift = (state == S_BHI) && tick && (bit_idx != LAST_BIT);

  i2cm_byte_shifter #(.W(DATA_W)) u_shift (
    .clk     (clk),
    .rst     (rst),
    .load    (sh_load),
    .load_val(sh_init),
    .shift   (sh_shift),
    .shin    (sda_s),
    .data    (sh_data),
    .msb     (sh_msb)
  );

  // value of SDA enable for the bit currently being sent
  always_comb sda_tgt = (bit_idx == LAST_BIT) ? !ninth_rel : !sh_msb;

  assign cmd_busy = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      scl_oe    <= 1'b0;
      sda_oe    <= 1'b0;
      done      <= 1'b0;
      bus_busy  <= 1'b0;
      ack_seen  <= 1'b0;
      rdata     <= '0;
      bit_idx   <= '0;
      ninth_rel <= 1'b1;
      is_read   <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (accept) begin
            unique case (cmd_op)
              OP_START: state <= S_ST0;
              OP_STOP: begin
                state  <= S_SP0;
                scl_oe <= 1'b1;
              end
              default: begin
                state     <= S_BLO;
                bit_idx   <= '0;
                is_read   <= (cmd_op == OP_READ);
                ninth_rel <= (cmd_op == OP_READ) ? cmd_rd_nack : 1'b1;
              end
            endcase
          end
        end
        // begin condition: release SDA, release SCL, pull SDA, pull SCL
        S_ST0: begin
          sda_oe <= 1'b0;
          if (tick && !sda_oe) begin
            state  <= S_ST1;
            scl_oe <= 1'b0;
          end
        end
        S_ST1: begin
          if (tick) begin
            state  <= S_ST2;
            sda_oe <= 1'b1;
          end
        end
        S_ST2: begin
          if (tick) begin
            state  <= S_ST3;
            scl_oe <= 1'b1;
          end
        end
        S_ST3: begin
          if (tick) begin
            state    <= S_IDLE;
            done     <= 1'b1;
            bus_busy <= 1'b1;
          end
        end
        // bit low phase: SDA settles one clock after SCL is low
        S_BLO: begin
          sda_oe <= sda_tgt;
          if (tick && (sda_oe == sda_tgt)) begin
            state  <= S_BHI;
            scl_oe <= 1'b0;
          end
        end
        // bit high phase: sample at its end
        S_BHI: begin
          if (tick) begin
            scl_oe <= 1'b1;
            if (bit_idx == LAST_BIT) begin
              ack_seen <= !sda_s;
              if (is_read) rdata <= sh_data;
              state <= S_IDLE;
              done  <= 1'b1;
            end else begin
              bit_idx <= bit_idx + 1'b1;
              state   <= S_BLO;
            end
          end
        end
        // end condition: pull SDA, release SCL, release SDA, bus-free wait
        S_SP0: begin
          sda_oe <= 1'b1;
          if (tick && sda_oe) begin
            state  <= S_SP1;
            scl_oe <= 1'b0;
          end
        end
        S_SP1: begin
          if (tick) begin
            state  <= S_SP2;
            sda_oe <= 1'b0;
          end
        end
        S_SP2: begin
          if (tick) begin
            state    <= S_IDLE;
            done     <= 1'b1;
            bus_busy <= 1'b0;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/i2cm_checker.sv
module i2cm_checker
  import i2cm_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             cmd_valid,
  input logic             cmd_busy,
  input logic             scl_oe,
  input logic             sda_oe,
  input logic             done,
  input logic             bus_busy,
  input logic             scl_s,
  input logic [DIV_W-1:0] half_div,
  input i2cm_state_e      state
);

  int unsigned hi_cnt;
  int unsigned span;

  always_comb span = (half_div == '0) ? 1 : int'(half_div);

  always_ff @(posedge clk) begin
    if (rst || state != S_BHI) hi_cnt <= 0;
    else if (scl_s)            hi_cnt <= hi_cnt + 1;
  end

  assert_start_edge_R2: assert property (@(posedge clk) disable iff (rst)
    ($rose(sda_oe) && !scl_oe && $past(!scl_oe)) |-> (state == S_ST2));

  assert_busy_set_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_busy) |-> done);

  assert_stop_edge_R3: assert property (@(posedge clk) disable iff (rst)
    ($fell(sda_oe) && !scl_oe && $past(!scl_oe)) |-> (state == S_SP2));

  assert_busy_clr_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_busy) |-> done);

  assert_high_len_R7: assert property (@(posedge clk) disable iff (rst)
    ($rose(scl_oe) && $past(state == S_BHI)) |-> ($past(hi_cnt) + 1 >= span));

  assert_stretch_wait_R8: assert property (@(posedge clk) disable iff (rst)
    (state == S_BHI && !scl_s) |=> (state == S_BHI));

  assert_ignore_R9: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_busy && state == S_BLO) |=> (state == S_BLO || state == S_BHI));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> !cmd_busy);

endmodule

bind i2c_byte_master i2cm_checker #(.DIV_W(DIV_W)) u_i2cm_checker (
  .clk      (clk),
  .rst      (rst),
  .cmd_valid(cmd_valid),
  .cmd_busy (cmd_busy),
  .scl_oe   (scl_oe),
  .sda_oe   (sda_oe),
  .done     (done),
  .bus_busy (bus_busy),
  .scl_s    (scl_s),
  .half_div (half_div),
  .state    (state)
);

// File: tb/i2c_byte_master_bench.sv
module i2c_byte_master_bench;

  localparam int SYNC = 2;

  logic        clk = 1'b0;
  logic        rst;
  logic        cmd_valid;
  logic [1:0]  cmd_op;
  logic        cmd_rd_nack;
  logic [7:0]  cmd_wdata;
  logic [15:0] half_div;
  logic        scl_oe, sda_oe, ack_seen, cmd_busy, bus_busy, done;
  logic [7:0]  rdata;

  always #5 clk = ~clk;

  // open-drain lines with pull-ups
  logic slv_drive;
  int   hold_cnt;
  wire  tb_scl_hold = (hold_cnt != 0);
  wire  scl_line = !(scl_oe || tb_scl_hold);
  wire  sda_line = !(sda_oe || slv_drive);

  i2c_byte_master #(.DATA_W(8), .DIV_W(16), .SYNC_STAGES(SYNC)) u_i2c_byte_master (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_rd_nack(cmd_rd_nack), .cmd_wdata(cmd_wdata), .half_div(half_div),
    .scl_in(scl_line), .sda_in(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .rdata(rdata), .ack_seen(ack_seen), .cmd_busy(cmd_busy),
    .bus_busy(bus_busy), .done(done)
  );

  int n_cmp = 0;
  int n_bad = 0;

  // slave and bus monitor
  int   mode;        // 0 none, 1 slave receives, 2 slave sends
  logic slv_ack;
  logic [7:0] slv_rd;
  int   stretch;
  logic prev_scl, prev_sda, hi_clean, mon_ack;
  logic [7:0] mon_sr;
  int bitn, hi_len, lo_len, n_start, n_stop, n_hi, bad_hi, bad_lo, cyc, stop_cyc;

  function automatic int exp_hi();
    return ((half_div == 0) ? 1 : int'(half_div)) + SYNC;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      prev_scl <= 1'b1; prev_sda <= 1'b1; hi_clean <= 1'b0; mon_ack <= 1'b1;
      mon_sr <= '0; bitn <= 0; hi_len <= 0; lo_len <= 1000; n_start <= 0;
      n_stop <= 0; n_hi <= 0; bad_hi <= 0; bad_lo <= 0; cyc <= 0; stop_cyc <= 0;
      hold_cnt <= 0; slv_drive <= 1'b0;
    end else begin
      cyc <= cyc + 1;
      prev_scl <= scl_line;
      prev_sda <= sda_line;
      if (hold_cnt > 0) hold_cnt <= hold_cnt - 1;
      if (prev_scl && scl_line && prev_sda && !sda_line) begin
        n_start <= n_start + 1; bitn <= 0; hi_clean <= 1'b0;
      end
      if (prev_scl && scl_line && !prev_sda && sda_line) begin
        n_stop <= n_stop + 1; bitn <= 0; hi_clean <= 1'b0; stop_cyc <= cyc;
      end
      if (!prev_scl && scl_line) begin
        hi_len <= 1; hi_clean <= 1'b1;
        if (lo_len < int'(half_div)) bad_lo <= bad_lo + 1;
        if (bitn < 8) mon_sr <= {mon_sr[6:0], sda_line};
        else          mon_ack <= sda_line;
        bitn <= (bitn == 8) ? 0 : bitn + 1;
      end else if (scl_line) begin
        hi_len <= hi_len + 1;
      end
      if (prev_scl && !scl_line) begin
        if (hi_clean) begin
          n_hi <= n_hi + 1;
          if (hi_len != exp_hi()) bad_hi <= bad_hi + 1;
        end
        hi_clean <= 1'b0;
        lo_len <= 1;
        if (stretch > 0) hold_cnt <= stretch;
      end else if (!scl_line) begin
        lo_len <= lo_len + 1;
      end
      if (!scl_line)
        slv_drive <= (mode == 1 && bitn == 8 && slv_ack) ||
                     (mode == 2 && bitn < 8 && !slv_rd[7 - bitn]);
    end
  end

  task automatic chk(input string what, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  int done_cyc;

  task automatic run_cmd(input logic [1:0] op, input logic [7:0] wd,
                         input logic nk, input bit inject);
    int w;
    @(negedge clk);
    cmd_op = op; cmd_wdata = wd; cmd_rd_nack = nk; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R10 busy after accept", cmd_busy, 1);
    if (inject) begin
      repeat (3) @(negedge clk);
      cmd_op = 2'd0; cmd_valid = 1'b1;   // R9: begin request while busy
      @(negedge clk);
      cmd_valid = 1'b0;
    end
    w = 0;
    while (!done && w < 5000) begin
      @(negedge clk);
      w++;
    end
    chk("R10 done reached", int'(done), 1);
    chk("R10 idle at done", int'(cmd_busy), 0);
    done_cyc = cyc;
    @(negedge clk);
    chk("R10 done single cycle", int'(done), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int divs [4] = '{1, 2, 3, 5};
    int s0, p0, nb, step;
    logic [7:0] v;
    rst = 1'b1; cmd_valid = 1'b0; cmd_op = '0; cmd_rd_nack = 1'b0; cmd_wdata = '0;
    half_div = 16'd3; mode = 0; slv_ack = 1'b0; slv_rd = '0; stretch = 0;
    repeat (4) @(negedge clk);
    chk("R1 scl_oe in reset", int'(scl_oe), 0);
    chk("R1 sda_oe in reset", int'(sda_oe), 0);
    chk("R1 cmd_busy in reset", int'(cmd_busy), 0);
    chk("R1 bus_busy in reset", int'(bus_busy), 0);
    chk("R1 done in reset", int'(done), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 lines released after reset", int'(scl_line && sda_line), 1);

    for (int di = 0; di < 4; di++) begin
      half_div = 16'(divs[di]);
      s0 = n_start; p0 = n_stop;
      run_cmd(2'd0, 8'h00, 1'b0, 1'b0);
      chk("R2 begin seen", n_start, s0 + 1);
      chk("R2 bus_busy set", int'(bus_busy), 1);
      chk("R2 SCL low after begin", int'(scl_line), 0);
      nb   = (divs[di] <= 2) ? 256 : 24;
      step = (divs[di] <= 2) ? 1 : 11;
      for (int k = 0; k < nb; k++) begin
        v = 8'((k * step) & 255);
        mode = 1; slv_ack = v[0] ^ v[3];
        run_cmd(2'd2, v, 1'b0, 1'b0);
        mode = 0;
        chk("R5 byte on bus", int'(mon_sr), int'(v));
        chk("R5 ack_seen", int'(ack_seen), int'(v[0] ^ v[3]));
        mode = 2; slv_rd = v ^ 8'hA5;
        run_cmd(2'd3, 8'h00, v[1], 1'b0);
        mode = 0;
        chk("R6 rdata", int'(rdata), int'(v ^ 8'hA5));
        chk("R6 ninth bit level", int'(mon_ack), int'(v[1]));
      end
      chk("R4 no begin inside bytes", n_start, s0 + 1);
      chk("R4 no end inside bytes", n_stop, p0);
      chk("R7 high pulse length", bad_hi, 0);
      chk("R7 low pulse length", bad_lo, 0);
      run_cmd(2'd1, 8'h00, 1'b0, 1'b0);
      chk("R3 end seen", n_stop, p0 + 1);
      chk("R3 bus_busy cleared", int'(bus_busy), 0);
      chk("R3 bus-free gap", done_cyc - stop_cyc, divs[di]);
    end
    chk("R7 pulses measured", int'(n_hi > 1000), 1);

    // R8: clock stretching by the slave
    half_div = 16'd2; stretch = 12;
    run_cmd(2'd0, 8'h00, 1'b0, 1'b0);
    mode = 1; slv_ack = 1'b1;
    run_cmd(2'd2, 8'h96, 1'b0, 1'b0);
    mode = 0;
    chk("R8 byte under stretch", int'(mon_sr), 32'h96);
    chk("R8 ack under stretch", int'(ack_seen), 1);
    mode = 2; slv_rd = 8'h3C;
    run_cmd(2'd3, 8'h00, 1'b1, 1'b0);
    mode = 0;
    chk("R8 rdata under stretch", int'(rdata), 32'h3C);
    chk("R8 high length under stretch", bad_hi, 0);
    stretch = 0;
    run_cmd(2'd1, 8'h00, 1'b0, 1'b0);

    // R9: request during a byte is ignored
    half_div = 16'd3;
    run_cmd(2'd0, 8'h00, 1'b0, 1'b0);
    s0 = n_start; p0 = n_stop;
    mode = 1; slv_ack = 1'b0;
    run_cmd(2'd2, 8'hC3, 1'b0, 1'b1);
    mode = 0;
    chk("R9 byte intact", int'(mon_sr), 32'hC3);
    chk("R9 no stray begin", n_start, s0);
    chk("R9 ack_seen nack", int'(ack_seen), 0);

    // R2: repeated begin while the bus is held
    run_cmd(2'd0, 8'h00, 1'b0, 1'b0);
    chk("R2 repeated begin seen", n_start, s0 + 1);
    chk("R2 no end before repeat", n_stop, p0);
    chk("R2 bus_busy kept", int'(bus_busy), 1);

    // R7: zero divider acts as one
    half_div = 16'd0;
    mode = 1; slv_ack = 1'b1;
    run_cmd(2'd2, 8'h5E, 1'b0, 1'b0);
    mode = 0;
    chk("R7 zero divider byte", int'(mon_sr), 32'h5E);
    chk("R7 zero divider high length", bad_hi, 0);
    run_cmd(2'd1, 8'h00, 1'b0, 1'b0);
    chk("R3 final bus free", int'(bus_busy), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule